// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Bus Slave

This block is the serial front end of a monitoring device on a two-wire, I2C-compatible bus. It acts only as a slave. The master drives SCL and creates every START and STOP. The block samples both lines with a fast system clock, passes them through synchronizers and finds bus events from their edges. Its only output to the bus is an open-drain pull-down enable for SDA. Its 7-bit bus address comes from three strap pins through a fixed, non-linear table.

When a header byte carries the block's address, the block acknowledges it. It then moves data bytes across a byte-wide handshake toward the register side. Each byte the master writes comes out with a one-cycle valid strobe. Each byte the master reads is fetched with a one-cycle request strobe. General-call and 10-bit headers are never acknowledged. A mode input selects this bus or the other serial interface; when the other one is selected, the block stays fully silent. After reset the block also stays silent for a programmable number of clock cycles.

Top module: `i2c_strap_slave`

## Requirements
- R1: The own address follows strap index {strap_a[2], strap_a[1], strap_a[0]} = {A0, A1, A2}: 000→1100001, 001→0101100, 010→1100100, 011→0101110, 100→1100010, 101→0101101, 110→1100101, 111→0101111.
- R2: After a header byte (7 address bits, MSB first, then R/W with 1 = read) whose address matches, sda_oe goes high after the eighth SCL falling edge. It stays high through the ninth SCL high phase and drops after the ninth falling edge.
- R3: A header whose address differs is not acknowledged. The general-call address 0000000 and any 11110xx header are never acknowledged. After any of these the block ignores the bus until the next START or STOP.
- R4: The block only pulls SDA low (sda_oe = 1) or releases it, and sda_oe changes only while the synchronized SCL is low.
- R5: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP, clocked bits produce no acknowledge and no strobe until a new START.
- R6: In a write transfer, each data byte (MSB first) appears on wr_data with wr_valid high for exactly one clock cycle, and the byte is acknowledged as in R2.
- R7: In a read transfer, rd_req pulses for one cycle after the matching header, before the first data bit. rd_data is then shifted out MSB first. A master ACK (SDA low on the ninth pulse) fetches the next byte with another rd_req pulse. A master NACK ends transmission until the next START.
- R8: A repeated START at any point, including the middle of a byte, returns the block to header reception with no STOP needed.
- R9: While if_sel is high (other interface selected), sda_oe stays low and neither wr_valid nor rd_req ever pulses.
- R10: For HOLDOFF_CYCLES clock cycles after rst_n rises, the block ignores all bus traffic and never drives SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a | input | 3 | Address straps, bit 2 = A0, bit 1 = A1, bit 0 = A2 |
| if_sel | input | 1 | 0 selects this bus, 1 keeps the block silent |
| wr_data | output | 8 | Last byte written by the master |
| wr_valid | output | 1 | One-cycle strobe for a new wr_data byte |
| rd_req | output | 1 | One-cycle request for the next byte to transmit |
| rd_data | input | 8 | Byte to transmit, stable from rd_req until it is shifted out |

## Verification
A wrong bit count or a stale state shows up on the bus within one byte. The acknowledge appears on the wrong pulse, or a byte is refused, and the master model sees this at the ninth clock. A header that is shifted wrongly or decoded from the wrong strap row shows as a missing or extra acknowledge on that same ninth pulse. A shift error in the data path shows in wr_data or in the read byte when the byte completes. Gating faults, meaning a drive during the hold-off window or with the other interface selected, show as an acknowledge or a strobe inside the first transfer attempted in that condition.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK,
    ST_RNEXT
  } slv_state_e;

  // strap index is {A0, A1, A2}
  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [2:0] s);
    case (s)
      3'b000:  strap_to_addr = 7'b1100001;
      3'b001:  strap_to_addr = 7'b0101100;
      3'b010:  strap_to_addr = 7'b1100100;
      3'b011:  strap_to_addr = 7'b0101110;
      3'b100:  strap_to_addr = 7'b1100010;
      3'b101:  strap_to_addr = 7'b0101101;
      3'b110:  strap_to_addr = 7'b1100101;
      default: strap_to_addr = 7'b0101111;
    endcase
  endfunction

  // general call and 10-bit headers are refused whatever the own address
  function automatic logic addr_ok(input logic [ADDR_W-1:0] hdr,
                                   input logic [ADDR_W-1:0] own);
    logic reserved;
    reserved = (hdr == '0) || (hdr[ADDR_W-1:2] == 5'b11110);
    addr_ok  = !reserved && (hdr == own);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  localparam int PW = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [PW-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[PW-2:0], din[g]};
    end
    assign lvl[g]  = pipe[STAGES-1];
    assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/i2c_holdoff_timer.sv
module i2c_holdoff_timer #(
  parameter int HOLDOFF_CYCLES = 31250
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(HOLDOFF_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2c_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid,
  output logic              rd_req,
  output logic              sda_oe
);
  slv_state_e        state;
  logic [2:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              rw_q;
  logic              drive_q;

  wire               last_bit = (bitcnt == 3'd7);
  wire [BYTE_W-1:0]  rx_byte  = {shreg[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      rw_q     <= 1'b0;
      drive_q  <= 1'b0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (!en) begin
        state   <= ST_IDLE;
        drive_q <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        drive_q <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 1'b1;
            if (last_bit) begin
              if (addr_ok(shreg[ADDR_W-1:0], own_addr)) begin
                rw_q   <= sda_lvl;
                rd_req <= sda_lvl;
                state  <= ST_AACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (!drive_q) drive_q <= 1'b1;
            else begin
              bitcnt <= '0;
              if (rw_q) begin
                tx      <= rd_data;
                drive_q <= ~rd_data[BYTE_W-1];
                state   <= ST_RBYTE;
              end else begin
                drive_q <= 1'b0;
                state   <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 1'b1;
            if (last_bit) begin
              wr_data  <= rx_byte;
              wr_valid <= 1'b1;
              state    <= ST_WACK;
            end
          end
          ST_WACK: if (scl_fall) begin
            if (!drive_q) drive_q <= 1'b1;
            else begin
              drive_q <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_WBYTE;
            end
          end
          ST_RBYTE: if (scl_fall) begin
            if (last_bit) begin
              drive_q <= 1'b0;
              state   <= ST_RACK;
            end else begin
              tx      <= {tx[BYTE_W-2:0], 1'b0};
              drive_q <= ~tx[BYTE_W-2];
              bitcnt  <= bitcnt + 1'b1;
            end
          end
          ST_RACK: if (scl_rise) begin
            if (!sda_lvl) begin
              rd_req <= 1'b1;
              state  <= ST_RNEXT;
            end else begin
              state  <= ST_IDLE;
            end
          end
          ST_RNEXT: if (scl_fall) begin
            tx      <= rd_data;
            drive_q <= ~rd_data[BYTE_W-1];
            bitcnt  <= '0;
            state   <= ST_RBYTE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = drive_q & en;

  // R2: pulled low while SCL is high on the ninth pulse
  assert_ack_on_ninth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scl_rise && (state == ST_AACK || state == ST_WACK)) |-> drive_q);

  // R4: the pull-down only moves while SCL is low
  assert_sda_change_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(drive_q)) |-> !scl_lvl);

  // R6: write strobe lasts one cycle and comes with a completed byte
  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_wr_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (state == ST_WACK || !en || state == ST_ADDR || state == ST_IDLE));

  // R7: read request lasts one cycle and precedes transmission
  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R8: any START brings the header phase back at bit zero
  assert_restart_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_ev) |=> (state == ST_ADDR && bitcnt == 3'd0));
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 31250,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        strap_a,
  input  logic              if_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam int LN_SCL = 0;
  localparam int LN_SDA = 1;

  logic [1:0] lvl, rise, fall;
  logic       hold_done;
  logic       bus_en;
  logic       start_ev, stop_ev;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sda_in, scl_in}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  i2c_holdoff_timer #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .done (hold_done)
  );

  assign start_ev = fall[LN_SDA] & lvl[LN_SCL];
  assign stop_ev  = rise[LN_SDA] & lvl[LN_SCL];
  assign bus_en   = hold_done & ~if_sel;

  i2c_slave_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (bus_en),
    .own_addr(strap_to_addr(strap_a)),
    .scl_lvl (lvl[LN_SCL]),
    .scl_rise(rise[LN_SCL]),
    .scl_fall(fall[LN_SCL]),
    .sda_lvl (lvl[LN_SDA]),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .rd_data (rd_data),
    .wr_data (wr_data),
    .wr_valid(wr_valid),
    .rd_req  (rd_req),
    .sda_oe  (sda_oe)
  );

  // R9: other interface selected means a silent bus pin
  assert_spi_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    if_sel |-> !sda_oe);

  // R10: nothing reaches the bus or the register side during hold-off
  assert_holdoff_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_done |-> !(sda_oe || wr_valid || rd_req));
endmodule

// File: tb/i2c_strap_slave_test.sv
`timescale 1ns/1ps
module i2c_strap_slave_test;
  localparam int HOLD = 3000;
  localparam int H    = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       if_sel = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [7:0] wr_data;
  logic       wr_valid, rd_req, sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int oe_glitch = 0;
  int pulse_bad = 0;
  int spi_drive = 0;
  logic [7:0] wr_log [0:63];
  logic prev_oe = 1'b0;
  logic prev_wv = 1'b0;
  logic prev_rq = 1'b0;

  always #4 clk = ~clk;

  i2c_strap_slave #(.HOLDOFF_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_a(strap), .if_sel(if_sel), .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_req(rd_req), .rd_data(rd_data));

  // bench view of the strap table: two families, arithmetic offsets
  function automatic logic [6:0] exp_addr(input logic [2:0] s);
    logic a0, a1, a2;
    a0 = s[2]; a1 = s[1]; a2 = s[0];
    if (a2) exp_addr = 7'h2C + {5'd0, a1, a0};
    else    exp_addr = 7'h61 + 7'(a1) * 7'd3 + 7'(a0);
  endfunction

  function automatic logic [7:0] rd_pat(input int n);
    rd_pat = 8'(8'hA5 ^ (n * 37));
  endfunction

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_log[wr_cnt % 64] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rd_req) begin
      rd_data <= rd_pat(rd_cnt);
      rd_cnt  <= rd_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (sda_oe != prev_oe && scl) oe_glitch++;
    if ((wr_valid && prev_wv) || (rd_req && prev_rq)) pulse_bad++;
    if (if_sel && (sda_oe || wr_valid || rd_req)) spi_drive++;
    prev_oe = sda_oe;
    prev_wv = wr_valid;
    prev_rq = rd_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
  endtask

  task automatic bit_in(output logic v);
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H/2); v = sda_line; wt(H/2); scl = 1'b0;
  endtask

  // returns 1 when the slave acknowledged
  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(v);
    acked = !v;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(!ack);
  endtask

  logic       ak;
  logic [7:0] rb, d0, d1;
  logic [6:0] wrong;
  int         base, wbase, seed;

  initial begin
    seed = $urandom(32'd20240611);
    wt(20);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(wr_valid == 1'b0 && rd_req == 1'b0, "R10 reset strobes", {wr_valid, rd_req}, 0);
    rst_n = 1'b1;

    // R10: a matching write inside the hold-off window is ignored
    bus_start();
    send_byte({exp_addr(3'd0), 1'b0}, ak);
    chk(!ak, "R10 holdoff header ack", ak, 0);
    send_byte(8'h3C, ak);
    chk(!ak && wr_cnt == 0, "R10 holdoff data", wr_cnt, 0);
    bus_stop();
    wt(HOLD);

    // R1 R2 R6: every strap row, two written bytes each
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      d0 = 8'($urandom); d1 = 8'($urandom);
      wbase = wr_cnt;
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, ak);
      chk(ak, "R1 R2 strap header ack", ak, 1);
      send_byte(d0, ak);
      chk(ak, "R6 data ack 0", ak, 1);
      send_byte(d1, ak);
      chk(ak, "R6 data ack 1", ak, 1);
      bus_stop();
      chk(wr_cnt == wbase + 2, "R6 strobe count", wr_cnt - wbase, 2);
      chk(wr_log[wbase % 64] == d0, "R6 byte 0", wr_log[wbase % 64], d0);
      chk(wr_log[(wbase + 1) % 64] == d1, "R6 byte 1", wr_log[(wbase + 1) % 64], d1);
      // R3: neighbouring address refused
      wrong = exp_addr(strap) ^ 7'(($urandom % 127) + 1);
      bus_start();
      send_byte({wrong, 1'b0}, ak);
      chk(!ak, "R3 wrong address", ak, 0);
      send_byte(8'h55, ak);
      chk(!ak && wr_cnt == wbase + 2, "R3 ignored after mismatch", wr_cnt - wbase, 2);
      bus_stop();
    end

    // R3: general call and 10-bit header
    strap = 3'd5;
    bus_start();
    send_byte(8'h00, ak);
    chk(!ak, "R3 general call", ak, 0);
    bus_stop();
    bus_start();
    send_byte({5'b11110, 2'($urandom), 1'b0}, ak);
    chk(!ak, "R3 ten-bit header", ak, 0);
    bus_stop();

    // R7: read three bytes, ACK, ACK, NACK
    base = rd_cnt;
    bus_start();
    send_byte({exp_addr(strap), 1'b1}, ak);
    chk(ak, "R7 read header ack", ak, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, rb);
      chk(rb == rd_pat(base + k), "R7 read byte", rb, rd_pat(base + k));
    end
    chk(rd_cnt == base + 3, "R7 request count", rd_cnt - base, 3);
    for (int i = 0; i < 9; i++) bit_in(ak);
    chk(rd_cnt == base + 3 && sda_oe == 1'b0, "R7 silent after NACK", rd_cnt - base, 3);
    bus_stop();

    // R8: repeated START from write to read
    base = rd_cnt; wbase = wr_cnt;
    bus_start();
    send_byte({exp_addr(strap), 1'b0}, ak);
    send_byte(8'hC3, ak);
    bus_start();
    send_byte({exp_addr(strap), 1'b1}, ak);
    chk(ak, "R8 restart header ack", ak, 1);
    recv_byte(1'b0, rb);
    chk(rb == rd_pat(base), "R8 read after restart", rb, rd_pat(base));
    bus_stop();
    chk(wr_log[wbase % 64] == 8'hC3, "R8 byte before restart", wr_log[wbase % 64], 8'hC3);

    // R8: repeated START in the middle of a data byte
    wbase = wr_cnt;
    bus_start();
    send_byte({exp_addr(strap), 1'b0}, ak);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start();
    send_byte({exp_addr(strap), 1'b0}, ak);
    chk(ak, "R8 mid-byte restart ack", ak, 1);
    send_byte(8'h81, ak);
    bus_stop();
    chk(wr_cnt == wbase + 1 && wr_log[wbase % 64] == 8'h81, "R8 mid-byte data",
        wr_log[wbase % 64], 8'h81);

    // R5: bits clocked after a STOP without START
    wbase = wr_cnt;
    scl = 1'b0; wt(H);
    send_byte({exp_addr(strap), 1'b0}, ak);
    chk(!ak, "R5 no START no ack", ak, 0);
    send_byte(8'h77, ak);
    chk(wr_cnt == wbase, "R5 no strobe after STOP", wr_cnt - wbase, 0);
    bus_stop();

    // R9: other interface selected
    if_sel = 1'b1;
    wbase = wr_cnt; base = rd_cnt;
    bus_start();
    send_byte({exp_addr(strap), 1'b0}, ak);
    chk(!ak, "R9 header ignored", ak, 0);
    send_byte(8'h12, ak);
    bus_stop();
    bus_start();
    send_byte({exp_addr(strap), 1'b1}, ak);
    chk(!ak && wr_cnt == wbase && rd_cnt == base, "R9 no strobes", wr_cnt - wbase, 0);
    bus_stop();
    if_sel = 1'b0;

    // random traffic, some with wrong addresses
    for (int n = 0; n < 16; n++) begin
      logic good;
      strap = 3'($urandom);
      good = ($urandom % 4) != 0;
      wrong = good ? exp_addr(strap) : exp_addr(strap) ^ 7'(($urandom % 127) + 1);
      d0 = 8'($urandom);
      wbase = wr_cnt;
      bus_start();
      send_byte({wrong, 1'b0}, ak);
      chk(ak == good, "R1 R3 random header", ak, good);
      send_byte(d0, ak);
      bus_stop();
      if (good) chk(wr_log[wbase % 64] == d0, "R6 random byte", wr_log[wbase % 64], d0);
      else      chk(wr_cnt == wbase, "R3 random ignore", wr_cnt - wbase, 0);
    end

    chk(oe_glitch == 0, "R4 sda_oe moved with SCL high", oe_glitch, 0);
    chk(pulse_bad == 0, "R6 R7 strobe width", pulse_bad, 0);
    chk(spi_drive == 0, "R9 activity with if_sel high", spi_drive, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule